// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a row of peripheral interrupt requests and a small group of non-maskable trap requests and reduces them to a single request toward the CPU. With that request it supplies the winning vector number and the program-memory address of that vector's entry. The CPU later fetches the service-routine address from that entry. Each maskable source has an enable bit and a 3-bit level. Traps are never masked and always beat maskable sources. Among eligible maskable sources the highest level wins. A tie goes to the lowest vector number.

Request pulses are caught in per-vector pending flags. Whenever no request is being presented, the block picks a winner from those flags and registers it. The winner is then held unchanged until the CPU acknowledges it. The acknowledge clears that vector's pending flag. The vector address comes from either the primary table or an alternate table of the same layout that sits directly after it. A control bit written through the configuration port chooses between them, and the choice can change at run time.

Top module: `pvic_top`

## Requirements
- R1: Traps use vectors 0 to 7. Maskable source k uses vector 8+k. A pending trap is always presented ahead of every maskable source, whatever the value of `cpu_pri`.
- R2: A maskable source is presented only when its enable bit is 1, its level is non-zero and its level is strictly greater than `cpu_pri`. A request that is not eligible stays pending and is presented once it becomes eligible.
- R3: Among eligible maskable sources, the source with the highest level wins.
- R4: Between sources of equal rank, the lower vector number wins. This holds both for traps and for maskable sources of the same level.
- R5: `vec_addr` = base + 2 × `vec_num`. The primary base is 0x000004. The alternate base is 0x000100, which is the primary base plus two address units for each of the 126 vectors.
- R6: Configuration writes (`cfg_we`=1) are decoded by `cfg_addr`. Address 0 is the control word, and only its bit 15 is used: 1 selects the alternate table. Address 1+k sets maskable source k: bit 3 is the enable and bits 2:0 are the level. All other bits and addresses are ignored.
- R7: The latency is fixed. A request that is high at clock edge e becomes pending at e. With nothing else in the way, `irq_out` rises after edge e+1, for any source.
- R8: While `irq_out` is 1 and `cpu_ack` is 0, `vec_num` and `vec_addr` stay unchanged, even if higher-ranked requests arrive.
- R9: When `cpu_ack` is 1 while `irq_out` is 1, the presented vector's pending flag is cleared and `irq_out` is 0 in the next cycle. The next winner is registered one edge later. When `cpu_ack` is 1 while `irq_out` is 0, it has no effect.
- R10: A new request for the vector being acknowledged, arriving in the acknowledge cycle, stays pending and is presented again.
- R11: After reset, `irq_out`, `vec_num` and `vec_addr` are 0, all enables and levels are 0, the primary table is selected and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration word select |
| cfg_wdata | input | 16 | Configuration write data |
| trap_req | input | 8 | Non-maskable trap request pulses |
| irq_req | input | 118 | Maskable interrupt request pulses |
| cpu_pri | input | 3 | Current CPU priority level |
| cpu_ack | input | 1 | CPU accepts the presented vector |
| irq_out | output | 1 | Request to the CPU |
| vec_num | output | 7 | Presented vector number |
| vec_addr | output | 24 | Program address of the presented vector entry |

## Verification
The acknowledge of a presented vector and a fresh request for that same vector can land in the same clock cycle. One path clears the pending flag while the other sets it. The bench provokes this by raising `cpu_ack` and the same source's request bit at one falling edge. It then requires `irq_out` to be low for exactly one cycle and to return with the same vector one cycle later. A second collision occurs when a higher-ranked trap arrives while a request is held. That case is judged by checking that the held vector stays unchanged until the acknowledge, and that the trap is presented right after it.

// File: rtl/pvic_pkg.sv
package pvic_pkg;

  parameter int unsigned PC_W = 24;

  typedef logic [PC_W-1:0] pc_t;
  typedef logic [3:0]      rank_t;

  // Traps rank above the highest user level (7).
  localparam rank_t TRAP_RANK = 4'd8;

  // Address of one vector entry: each entry is one two-unit program word.
  function automatic pc_t entry_addr(pc_t base, int unsigned vec);
    return base + pc_t'(vec << 1);
  endfunction

  // Arbitration rank of a maskable source; 0 means it does not compete.
  function automatic rank_t src_rank(logic pend, logic en, logic [2:0] lvl,
                                     logic [2:0] cpu);
    if (pend && en && (lvl != 3'd0) && (lvl > cpu))
      return {1'b0, lvl};
    return '0;
  endfunction

endpackage

// File: rtl/pvic_cfg_regs.sv
module pvic_cfg_regs #(
  parameter int unsigned N_IRQ = 118,
  parameter int unsigned CA_W  = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [CA_W-1:0]       addr,
  input  logic [15:0]           wdata,
  output logic [N_IRQ-1:0]      en,
  output logic [N_IRQ-1:0][2:0] lvl,
  output logic                  alt_sel
);

  localparam int unsigned ALT_BIT = 15;

  logic unused_wdata;
  assign unused_wdata = ^wdata[14:4];

  // control word at address 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      alt_sel <= 1'b0;
    else if (we && (addr == '0))
      alt_sel <= wdata[ALT_BIT];
  end

  // one setting word per maskable source at address 1+k
  for (genvar k = 0; k < N_IRQ; k++) begin : g_src
    logic hit;
    assign hit = we && (addr == CA_W'(k + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en[k]  <= 1'b0;
        lvl[k] <= 3'd0;
      end else if (hit) begin
        en[k]  <= wdata[3];
        lvl[k] <= wdata[2:0];
      end
    end
  end

endmodule

// File: rtl/pvic_pending.sv
module pvic_pending #(
  parameter int unsigned N = 126
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);

  // a request in the same cycle as a clear wins, so no event is lost
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pend[i] <= 1'b0;
      else
        pend[i] <= req[i] | (pend[i] & ~clr[i]);
    end
  end

endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter
  import pvic_pkg::*;
#(
  parameter int unsigned N_TRAP = 8,
  parameter int unsigned N_IRQ  = 118,
  parameter int unsigned VEC_W  = 7,
  localparam int unsigned N_VEC = N_TRAP + N_IRQ
) (
  input  logic [N_VEC-1:0]      pend,
  input  logic [N_IRQ-1:0]      en,
  input  logic [N_IRQ-1:0][2:0] lvl,
  input  logic [2:0]            cpu_pri,
  output logic                  found,
  output logic [VEC_W-1:0]      win_vec,
  output rank_t                 win_rank
);

  rank_t rank [N_VEC];

  for (genvar t = 0; t < N_TRAP; t++) begin : g_trap
    assign rank[t] = pend[t] ? TRAP_RANK : '0;
  end

  for (genvar k = 0; k < N_IRQ; k++) begin : g_irq
    assign rank[N_TRAP + k] = src_rank(pend[N_TRAP + k], en[k], lvl[k], cpu_pri);
  end

  // ascending scan with strict compare: the lowest vector keeps a tie
  always_comb begin
    win_rank = '0;
    win_vec  = '0;
    for (int i = 0; i < N_VEC; i++) begin
      if (rank[i] > win_rank) begin
        win_rank = rank[i];
        win_vec  = VEC_W'(i);
      end
    end
    found = (win_rank != '0);
  end

endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
#(
  parameter int unsigned N_TRAP   = 8,
  parameter int unsigned N_IRQ    = 118,
  parameter pc_t         PRI_BASE = 24'h000004,
  localparam int unsigned N_VEC   = N_TRAP + N_IRQ,
  localparam int unsigned VEC_W   = $clog2(N_VEC),
  localparam int unsigned CA_W    = $clog2(N_IRQ + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CA_W-1:0]   cfg_addr,
  input  logic [15:0]       cfg_wdata,
  input  logic [N_TRAP-1:0] trap_req,
  input  logic [N_IRQ-1:0]  irq_req,
  input  logic [2:0]        cpu_pri,
  input  logic              cpu_ack,
  output logic              irq_out,
  output logic [VEC_W-1:0]  vec_num,
  output pc_t               vec_addr
);

  localparam pc_t ALT_BASE = PRI_BASE + pc_t'(2 * N_VEC);

  logic [N_IRQ-1:0]      en;
  logic [N_IRQ-1:0][2:0] lvl;
  logic                  alt_sel;
  logic [N_VEC-1:0]      pend;
  logic [N_VEC-1:0]      clr;
  logic                  found;
  logic [VEC_W-1:0]      win_vec;
  rank_t                 win_rank;

  // named events, used by the checker
  logic hold;
  logic cap_evt;
  logic ack_evt;
  logic trap_pend_any;

  pvic_cfg_regs #(.N_IRQ(N_IRQ), .CA_W(CA_W)) cfg_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .en     (en),
    .lvl    (lvl),
    .alt_sel(alt_sel)
  );

  pvic_pending #(.N(N_VEC)) pend_i (
    .clk  (clk),
    .rst_n(rst_n),
    .req  ({irq_req, trap_req}),
    .clr  (clr),
    .pend (pend)
  );

  pvic_arbiter #(.N_TRAP(N_TRAP), .N_IRQ(N_IRQ), .VEC_W(VEC_W)) arb_i (
    .pend    (pend),
    .en      (en),
    .lvl     (lvl),
    .cpu_pri (cpu_pri),
    .found   (found),
    .win_vec (win_vec),
    .win_rank(win_rank)
  );

  assign cap_evt       = !hold && found;
  assign ack_evt       = hold && cpu_ack;
  assign trap_pend_any = |pend[N_TRAP-1:0];

  for (genvar i = 0; i < N_VEC; i++) begin : g_clr
    assign clr[i] = ack_evt && (vec_num == VEC_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold     <= 1'b0;
      vec_num  <= '0;
      vec_addr <= '0;
    end else if (hold) begin
      if (cpu_ack)
        hold <= 1'b0;
    end else if (found) begin
      hold     <= 1'b1;
      vec_num  <= win_vec;
      vec_addr <= entry_addr(alt_sel ? ALT_BASE : PRI_BASE, int'(win_vec));
    end
  end

  assign irq_out = hold;

endmodule

// File: rtl/pvic_chk.sv
module pvic_chk
  import pvic_pkg::*;
#(
  parameter int unsigned N_TRAP   = 8,
  parameter int unsigned VEC_W    = 7,
  parameter pc_t         PRI_BASE = 24'h000004,
  parameter pc_t         ALT_BASE = 24'h000100
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_out,
  input logic             cpu_ack,
  input logic [VEC_W-1:0] vec_num,
  input pc_t              vec_addr,
  input logic             cap_evt,
  input logic             trap_pend_any,
  input logic [VEC_W-1:0] win_vec,
  input rank_t            win_rank,
  input logic [2:0]       cpu_pri
);

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out && !cpu_ack |=> irq_out && $stable(vec_num) && $stable(vec_addr));

  a_r9_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out && cpu_ack |=> !irq_out);

  a_r1_trap_first: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt && trap_pend_any |=> irq_out && (int'(vec_num) < N_TRAP));

  a_r2_above_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt && (int'(win_vec) >= N_TRAP) |-> (win_rank > {1'b0, cpu_pri}));

  a_r5_addr_map: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (vec_addr == PRI_BASE + pc_t'({vec_num, 1'b0})) ||
                (vec_addr == ALT_BASE + pc_t'({vec_num, 1'b0})));

endmodule

bind pvic_top pvic_chk #(
  .N_TRAP  (N_TRAP),
  .VEC_W   (VEC_W),
  .PRI_BASE(PRI_BASE),
  .ALT_BASE(ALT_BASE)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq_out      (irq_out),
  .cpu_ack      (cpu_ack),
  .vec_num      (vec_num),
  .vec_addr     (vec_addr),
  .cap_evt      (cap_evt),
  .trap_pend_any(trap_pend_any),
  .win_vec      (win_vec),
  .win_rank     (win_rank),
  .cpu_pri      (cpu_pri)
);

// File: tb/pvic_top_tb_top.sv
`timescale 1ns/1ps
module pvic_top_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [6:0]   cfg_addr = '0;
  logic [15:0]  cfg_wdata = '0;
  logic [7:0]   trap_req = '0;
  logic [117:0] irq_req = '0;
  logic [2:0]   cpu_pri = '0;
  logic         cpu_ack = 1'b0;
  logic         irq_out;
  logic [6:0]   vec_num;
  logic [23:0]  vec_addr;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pvic_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .trap_req(trap_req), .irq_req(irq_req),
    .cpu_pri(cpu_pri), .cpu_ack(cpu_ack), .irq_out(irq_out),
    .vec_num(vec_num), .vec_addr(vec_addr)
  );

  // row: alt(1) cpu(3) trap(8) ia(7) pa(3) ib(7) pb(3) valid(1) vec(7)
  localparam int NROW = 9;
  localparam logic [39:0] TBL [NROW] = '{
    {1'b0, 3'd0, 8'h00, 7'd5,   3'd3, 7'd2,   3'd3, 1'b1, 7'd10},  // R4 tie
    {1'b0, 3'd0, 8'h00, 7'd5,   3'd6, 7'd2,   3'd3, 1'b1, 7'd13},  // R3
    {1'b0, 3'd5, 8'h00, 7'd5,   3'd6, 7'd2,   3'd7, 1'b1, 7'd10},  // R3
    {1'b0, 3'd6, 8'h00, 7'd5,   3'd6, 7'd2,   3'd6, 1'b0, 7'd0},   // R2
    {1'b0, 3'd7, 8'h20, 7'd5,   3'd7, 7'd2,   3'd7, 1'b1, 7'd5},   // R1
    {1'b1, 3'd0, 8'h06, 7'd5,   3'd7, 7'd2,   3'd7, 1'b1, 7'd1},   // R1 R4 R5
    {1'b1, 3'd0, 8'h00, 7'd117, 3'd1, 7'd0,   3'd1, 1'b1, 7'd8},   // R5
    {1'b0, 3'd0, 8'h00, 7'd117, 3'd4, 7'd100, 3'd2, 1'b1, 7'd125}, // R5
    {1'b0, 3'd3, 8'h00, 7'd10,  3'd3, 7'd11,  3'd4, 1'b1, 7'd19}   // R2
  };

  function automatic string row_req(int r);
    case (r)
      0: return "R4";
      1, 2: return "R3";
      3, 8: return "R2";
      4: return "R1";
      default: return "R5";
    endcase
  endfunction

  // R5 restated: primary base 0x4, alternate base 0x100, two units per entry
  function automatic logic [23:0] exp_addr(bit alt, int vec);
    logic [23:0] base;
    base = alt ? 24'h000100 : 24'h000004;
    return base + 24'(vec * 2);
  endfunction

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic wr(int a, logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 7'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(logic [7:0] t, int ia, int ib);
    @(negedge clk);
    trap_req = t;
    if (ia >= 0) irq_req[ia] = 1'b1;
    if (ib >= 0) irq_req[ib] = 1'b1;
    @(negedge clk);
    trap_req = '0; irq_req = '0;
  endtask

  task automatic ack();
    @(negedge clk);
    cpu_ack = 1'b1;
    @(negedge clk);
    cpu_ack = 1'b0;
  endtask

  task automatic drain();
    cpu_pri = 3'd0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (irq_out) begin
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
      end
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 irq_out", 32'(irq_out), 0);
    chk("R11 vec_num", 32'(vec_num), 0);
    chk("R11 vec_addr", 32'(vec_addr), 0);

    // table walk
    for (int r = 0; r < NROW; r++) begin
      logic [39:0] e;
      e = TBL[r];
      cpu_pri = e[38:36];
      wr(0, e[39] ? 16'h8000 : 16'h0000);
      wr(1 + int'(e[27:21]), {12'h0, 1'b1, e[20:18]});
      wr(1 + int'(e[17:11]), {12'h0, 1'b1, e[10:8]});
      pulse(e[35:28], int'(e[27:21]), int'(e[17:11]));
      @(negedge clk);
      chk({row_req(r), " row irq_out"}, 32'(irq_out), 32'(e[7]));
      if (e[7]) begin
        chk({row_req(r), " row vec_num"}, 32'(vec_num), 32'(e[6:0]));
        chk({row_req(r), " row vec_addr"}, 32'(vec_addr),
            32'(exp_addr(e[39], int'(e[6:0]))));
      end
      drain();
      wr(1 + int'(e[27:21]), 16'h0000);
      wr(1 + int'(e[17:11]), 16'h0000);
    end

    // R11 / R2: after reset a source is disabled, but its request is kept
    pulse(8'h00, 3, -1);
    @(negedge clk);
    chk("R11 disabled after reset", 32'(irq_out), 0);
    // R6: only bit 15 of the control word selects the table
    wr(0, 16'h7FFF);
    wr(1 + 3, 16'h000A);
    @(negedge clk);
    chk("R2 late eligible", 32'(irq_out), 1);
    chk("R6 vec", 32'(vec_num), 11);
    chk("R6 ctrl bits ignored", 32'(vec_addr), 32'h1A);
    ack();

    // R2: enable bit 0 with non-zero level is not presented
    wr(1 + 4, 16'h0005);
    pulse(8'h00, 4, -1);
    @(negedge clk);
    chk("R2 enable off", 32'(irq_out), 0);

    // R8 / R9: hold while a trap arrives, then re-arbitrate after ack
    wr(1 + 20, 16'h0009);
    pulse(8'h00, 20, -1);
    @(negedge clk);
    chk("R8 vec held", 32'(vec_num), 28);
    pulse(8'h01, -1, -1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 irq held", 32'(irq_out), 1);
      chk("R8 vec stable", 32'(vec_num), 28);
    end
    ack();
    chk("R9 drop after ack", 32'(irq_out), 0);
    @(negedge clk);
    chk("R9 next winner", 32'(irq_out), 1);
    chk("R9 trap vec", 32'(vec_num), 0);
    ack();

    // R9: ack while idle has no effect
    cpu_pri = 3'd7;
    wr(1 + 30, 16'h000A);
    pulse(8'h00, 30, -1);
    @(negedge clk);
    chk("R2 masked by cpu", 32'(irq_out), 0);
    ack();
    cpu_pri = 3'd0;
    @(negedge clk);
    chk("R9 idle ack ignored", 32'(irq_out), 1);
    chk("R9 idle ack vec", 32'(vec_num), 38);
    ack();

    // R10: ack and a new request for the same source in one cycle
    pulse(8'h00, 30, -1);
    @(negedge clk);
    chk("R10 presented", 32'(vec_num), 38);
    @(negedge clk);
    cpu_ack = 1'b1; irq_req[30] = 1'b1;
    @(negedge clk);
    cpu_ack = 1'b0; irq_req = '0;
    chk("R10 gap", 32'(irq_out), 0);
    @(negedge clk);
    chk("R10 re-presented", 32'(irq_out), 1);
    chk("R10 vec", 32'(vec_num), 38);
    ack();

    // R7: equal latency for a trap and a maskable source
    pulse(8'h08, -1, -1);
    chk("R7 trap not early", 32'(irq_out), 0);
    @(negedge clk);
    chk("R7 trap on time", 32'(irq_out), 1);
    chk("R7 trap vec", 32'(vec_num), 3);
    ack();
    wr(1 + 117, 16'h0009);
    pulse(8'h00, 117, -1);
    chk("R7 irq not early", 32'(irq_out), 0);
    @(negedge clk);
    chk("R7 irq on time", 32'(irq_out), 1);
    chk("R7 irq vec", 32'(vec_num), 125);
    ack();

    done = 1'b1;
    finish_run();
  end

endmodule